// File: doc/BRIEF.md
# Trigger Latency Pipeline with Event Derandomizer

This block holds every per-crossing front-end data word in a fixed-length shift pipeline that advances once per bunch-crossing clock. The pipeline length is the time the first-level trigger has to reach its decision. When the trigger accepts a crossing, its accept strobe arrives exactly one pipeline length after that crossing's word entered. The word leaving the pipeline on that clock and the two words after it are then stored together as one event in a small event buffer.

The event buffer holds a bounded number of events. It is drained one sample per ready/valid handshake, oldest event first, and the last sample of each event is flagged. Accepts come at a low average rate but can arrive in bursts. The buffer absorbs those bursts. A busy flag warns the trigger before the buffer fills. Accepts that find the buffer full are dropped and counted. Two or more accepts closer together than one capture window each form their own event, so a pipeline word can be stored in more than one event. No storage location is ever written twice for the same event.

Top module: `trig_latency_buffer`

## Requirements
- R1: An accept sampled on clock edge t stores, as one event, the `din` words sampled on edges t-PIPE_LEN, t-PIPE_LEN+1 and t-PIPE_LEN+2, and readout returns them in that order (PIPE_LEN defaults to 132).
- R2: Accepts on consecutive clocks each create a separate event with its own three samples, so samples common to the overlapping windows appear in every event that covers them.
- R3: An accept sampled while `buf_full` is high stores nothing and leaves the stored events unchanged. It raises `ovf_count` by one on the next clock, and `ovf_count` saturates at all ones.
- R4: `busy` is high whenever 7 or more events are stored. An event counts as stored from the edge that samples its accept until the edge that completes the handshake of its last sample.
- R5: `buf_full` is high exactly when 8 events are stored.
- R6: Readout gives one sample per clock on which `rd_valid` and `rd_ready` are both high. Events are read oldest first, and `rd_last` is high only on the third sample of an event.
- R7: `rd_valid` rises only once the oldest stored event has all three samples captured: two clocks after the edge that samples its accept, on an empty buffer. While `rd_ready` is low, `rd_valid`, `rd_data` and `rd_last` hold.
- R8: An active-low synchronous reset clears the pipeline to zero words, empties the buffer and clears `ovf_count`. An accept whose window reaches words from before reset returns zeros for them.
- R9: When an accept and the final-sample handshake of an event happen on the same clock, both take effect. The full decision uses the occupancy before that clock, so a full buffer still drops that accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | DATA_W | Front-end data word for the current crossing |
| accept | input | 1 | Trigger accept strobe for the crossing leaving the pipeline |
| rd_ready | input | 1 | Readout consumer ready |
| rd_data | output | DATA_W | Current readout sample |
| rd_valid | output | 1 | Readout sample available |
| rd_last | output | 1 | Readout sample is the last of its event |
| buf_full | output | 1 | Event buffer holds its maximum number of events |
| busy | output | 1 | Occupancy at or above the throttle level |
| ovf_count | output | OVF_W | Saturating count of dropped accepts |

## Verification
An accept and the handshake that retires an event's last sample can fall on the same clock. This changes occupancy up and down at once, and when the buffer is full it decides whether the accept is kept. The bench provokes this by filling the buffer with readout stalled, then raising `rd_ready` while holding `accept` high for several clocks, so one accept is certain to meet the retiring handshake. The scoreboard's occupancy model makes each drop decision from the count before that clock. It then judges the stored sample stream, `busy`, `buf_full` and `ovf_count` against that model on every clock.

// File: rtl/tlb_pkg.sv
// Shared sizing helpers for the trigger latency buffer.
// Assumes callers pass positive counts.
package tlb_pkg;

    // Width of an index that addresses n items (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must hold the values 0..n.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tlb_delay_line.sv
// Fixed-length latency pipeline: each word moves one cell per clock.
// dout is the word that was sampled on din PIPE_LEN edges earlier.
// Assumes PIPE_LEN >= 1; a synchronous reset clears every cell to zero.
module tlb_delay_line #(
    parameter int DATA_W   = 8,
    parameter int PIPE_LEN = 132
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [PIPE_LEN-1:0][DATA_W-1:0] cells;

    generate
        if (PIPE_LEN == 1) begin : g_single
            // Single-cell variant: one register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) cells <= '0;
                else        cells <= din;
            end
        end else begin : g_chain
            // Shift chain: cell 0 takes the input, others take their neighbour.
            always_ff @(posedge clk) begin
                if (!rst_n) cells <= '0;
                else        cells <= {cells[PIPE_LEN-2:0], din};
            end
        end
    endgenerate

    assign dout = cells[PIPE_LEN-1];

endmodule

// File: rtl/tlb_event_store.sv
// Event storage: EVENTS slots of SAMPLES words each.
// A slot is claimed by alloc and captures sample 0 on that edge. It then
// captures one pipeline word per clock until full, on its own fill counter,
// so overlapping capture windows never collide. Each word position of a
// slot is written once per event. free empties the slot.
// Assumes alloc is never aimed at an occupied slot (occupancy ensures it).
module tlb_event_store
    import tlb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SAMPLES = 3,
    parameter int EVENTS  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           alloc,
    input  logic [idx_width(EVENTS)-1:0]   alloc_slot,
    input  logic [DATA_W-1:0]              sample_in,
    input  logic                           free,
    input  logic [idx_width(EVENTS)-1:0]   rd_slot,
    input  logic [idx_width(SAMPLES)-1:0]  rd_idx,
    output logic [DATA_W-1:0]              rd_word,
    output logic                           head_done
);

    localparam int SLOT_W = idx_width(EVENTS);
    localparam int FILL_W = cnt_width(SAMPLES);

    logic [SAMPLES-1:0][DATA_W-1:0] slot_words [EVENTS];
    logic [FILL_W-1:0]              slot_fill  [EVENTS];

    generate
        for (genvar e = 0; e < EVENTS; e++) begin : g_slot
            logic [SAMPLES-1:0][DATA_W-1:0] words;
            logic [FILL_W-1:0]              fill;
            logic                           claim;
            logic                           release_now;
            logic                           capturing;

            assign claim       = alloc && (alloc_slot == SLOT_W'(e));
            assign release_now = free && (rd_slot == SLOT_W'(e));
            assign capturing   = (fill != '0) && (fill < FILL_W'(SAMPLES));

            // Fill tracking: claim, step through the window, release.
            always_ff @(posedge clk) begin
                if (!rst_n)           fill <= '0;
                else if (claim)       fill <= FILL_W'(1);
                else if (release_now) fill <= '0;
                else if (capturing)   fill <= fill + FILL_W'(1);
            end

            // Word capture: position 0 on claim, later positions by fill.
            always_ff @(posedge clk) begin
                if (claim) begin
                    words[0] <= sample_in;
                end else if (capturing) begin
                    for (int s = 1; s < SAMPLES; s++) begin
                        if (fill == FILL_W'(s)) words[s] <= sample_in;
                    end
                end
            end

            assign slot_words[e] = words;
            assign slot_fill[e]  = fill;
        end
    endgenerate

    assign rd_word   = slot_words[rd_slot][rd_idx];
    assign head_done = (slot_fill[rd_slot] == FILL_W'(SAMPLES));

endmodule

// File: rtl/tlb_readout.sv
// Readout sequencer: walks the oldest completed event one sample per
// handshake, flags its final sample, then moves to the next slot.
// Assumes slots are filled in the same circular order they are read.
module tlb_readout
    import tlb_pkg::*;
#(
    parameter int SAMPLES = 3,
    parameter int EVENTS  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          head_done,
    input  logic                          rd_ready,
    output logic                          rd_valid,
    output logic                          rd_last,
    output logic                          retire,
    output logic [idx_width(EVENTS)-1:0]  rd_slot,
    output logic [idx_width(SAMPLES)-1:0] rd_idx
);

    localparam int SLOT_W = idx_width(EVENTS);
    localparam int IDX_W  = idx_width(SAMPLES);

    logic take;

    assign rd_valid = head_done;
    assign rd_last  = head_done && (rd_idx == IDX_W'(SAMPLES - 1));
    assign take     = rd_valid && rd_ready;
    assign retire   = take && rd_last;

    // Sample and slot stepping on each completed handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx  <= '0;
            rd_slot <= '0;
        end else if (take) begin
            if (rd_last) begin
                rd_idx  <= '0;
                rd_slot <= (rd_slot == SLOT_W'(EVENTS - 1)) ? '0 : rd_slot + SLOT_W'(1);
            end else begin
                rd_idx <= rd_idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/tlb_occupancy.sv
// Occupancy and admission: counts stored events, admits accepts only
// when not full (judged on the count before the clock), hands out the
// next write slot, and keeps a saturating count of dropped accepts.
// Assumes BUSY_LEVEL <= EVENTS.
module tlb_occupancy
    import tlb_pkg::*;
#(
    parameter int EVENTS     = 8,
    parameter int BUSY_LEVEL = 7,
    parameter int OVF_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         accept,
    input  logic                         retire,
    output logic                         alloc,
    output logic [idx_width(EVENTS)-1:0] wr_slot,
    output logic                         buf_full,
    output logic                         busy,
    output logic [OVF_W-1:0]             ovf_count
);

    localparam int SLOT_W = idx_width(EVENTS);
    localparam int CNT_W  = cnt_width(EVENTS);

    logic [CNT_W-1:0] stored;
    logic             drop;

    assign buf_full = (stored == CNT_W'(EVENTS));
    assign busy     = (stored >= CNT_W'(BUSY_LEVEL));
    assign alloc    = accept && !buf_full;
    assign drop     = accept && buf_full;

    // Stored-event count: up on admission, down on retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else begin
            case ({alloc, retire})
                2'b10:   stored <= stored + CNT_W'(1);
                2'b01:   stored <= stored - CNT_W'(1);
                default: stored <= stored;
            endcase
        end
    end

    // Circular write slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_slot <= '0;
        else if (alloc) wr_slot <= (wr_slot == SLOT_W'(EVENTS - 1)) ? '0 : wr_slot + SLOT_W'(1);
    end

    // Saturating dropped-accept counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ovf_count <= '0;
        else if (drop && ~&ovf_count)  ovf_count <= ovf_count + OVF_W'(1);
    end

endmodule

// File: rtl/trig_latency_buffer.sv
// Top level: latency pipeline feeding an event buffer of fixed-size events.
// An accept on edge t captures the pipeline output on edges t, t+1, t+2
// (words that entered PIPE_LEN edges before each). Readout is ready/valid.
// Assumes one data word per clock and accepts already aligned to latency.
module trig_latency_buffer
    import tlb_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PIPE_LEN   = 132,
    parameter int SAMPLES    = 3,
    parameter int EVENTS     = 8,
    parameter int BUSY_LEVEL = 7,
    parameter int OVF_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              accept,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic              buf_full,
    output logic              busy,
    output logic [OVF_W-1:0]  ovf_count
);

    localparam int SLOT_W = idx_width(EVENTS);
    localparam int IDX_W  = idx_width(SAMPLES);

    logic [DATA_W-1:0] pipe_out;
    logic              alloc;
    logic              retire;
    logic              head_done;
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic [IDX_W-1:0]  rd_idx;

    tlb_delay_line #(
        .DATA_W   (DATA_W),
        .PIPE_LEN (PIPE_LEN)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .dout  (pipe_out)
    );

    tlb_occupancy #(
        .EVENTS     (EVENTS),
        .BUSY_LEVEL (BUSY_LEVEL),
        .OVF_W      (OVF_W)
    ) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .retire    (retire),
        .alloc     (alloc),
        .wr_slot   (wr_slot),
        .buf_full  (buf_full),
        .busy      (busy),
        .ovf_count (ovf_count)
    );

    tlb_event_store #(
        .DATA_W  (DATA_W),
        .SAMPLES (SAMPLES),
        .EVENTS  (EVENTS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc),
        .alloc_slot (wr_slot),
        .sample_in  (pipe_out),
        .free       (retire),
        .rd_slot    (rd_slot),
        .rd_idx     (rd_idx),
        .rd_word    (rd_data),
        .head_done  (head_done)
    );

    tlb_readout #(
        .SAMPLES (SAMPLES),
        .EVENTS  (EVENTS)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_done (head_done),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_last   (rd_last),
        .retire    (retire),
        .rd_slot   (rd_slot),
        .rd_idx    (rd_idx)
    );

endmodule

// File: rtl/tlb_checker.sv
// Port-level temporal checks for trig_latency_buffer, attached by bind.
// Assumes busy threshold does not exceed buffer depth.
module tlb_checker #(
    parameter int DATA_W = 8,
    parameter int OVF_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_last,
    input logic              buf_full,
    input logic              busy,
    input logic [OVF_W-1:0]  ovf_count
);

    assert_drop_counted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && buf_full && ~&ovf_count) |=> (ovf_count == $past(ovf_count) + OVF_W'(1)));

    assert_no_spurious_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && buf_full) |=> $stable(ovf_count));

    assert_full_means_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> busy);

    assert_busy_falls_on_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rd_valid && rd_ready && rd_last));

    assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !(rd_valid && rd_ready && rd_last)) |=> buf_full);

    assert_last_is_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

endmodule

bind trig_latency_buffer tlb_checker #(
    .DATA_W (DATA_W),
    .OVF_W  (OVF_W)
) u_tlb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_last   (rd_last),
    .buf_full  (buf_full),
    .busy      (busy),
    .ovf_count (ovf_count)
);

// File: tb/test_trig_latency_buffer.sv
// Scoreboard bench: the monitor models occupancy, queues expected samples
// on each admitted accept and compares every readout handshake.
module test_trig_latency_buffer;

    localparam int DW = 8;
    localparam int PL = 132;
    localparam int NS = 3;
    localparam int NE = 8;
    localparam int BL = 7;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic          accept = 1'b0;
    logic          rd_ready = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_last;
    logic          buf_full;
    logic          busy;
    logic [OW-1:0] ovf_count;

    typedef struct {
        logic [DW-1:0] val;
        logic          last;
        string         tag;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    int    stamp = 0;
    int    base = -1;
    int    model_count = 0;
    int    exp_ovf = 0;
    string cur_tag = "R1";

    trig_latency_buffer #(
        .DATA_W (DW), .PIPE_LEN (PL), .SAMPLES (NS),
        .EVENTS (NE), .BUSY_LEVEL (BL), .OVF_W (OW)
    ) i_trig_latency_buffer (
        .clk (clk), .rst_n (rst_n), .din (din), .accept (accept),
        .rd_ready (rd_ready), .rd_data (rd_data), .rd_valid (rd_valid),
        .rd_last (rd_last), .buf_full (buf_full), .busy (busy),
        .ovf_count (ovf_count)
    );

    always #10 clk = ~clk;

    // Counter pattern: din carries the crossing stamp.
    always @(posedge clk) begin
        #2;
        stamp++;
        din = DW'(stamp);
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] src_val(input int s);
        return (s >= base) ? DW'(s) : '0;
    endfunction

    // Monitor: status against model, then admission, then readout compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (base < 0) base = stamp;
            check(busy == (model_count >= BL), "R4", "busy", busy, model_count >= BL);
            check(buf_full == (model_count == NE), "R5", "buf_full", buf_full, model_count == NE);
            check(ovf_count == OW'(exp_ovf), "R3", "ovf_count", ovf_count, exp_ovf);
            if (accept) begin
                if (model_count == NE) begin
                    if (exp_ovf < (1 << OW) - 1) exp_ovf++;
                end else begin
                    for (int k = 0; k < NS; k++) begin
                        exp_t it;
                        it.val  = src_val(stamp - PL + k);
                        it.last = (k == NS - 1);
                        it.tag  = cur_tag;
                        sb_q.push_back(it);
                    end
                    model_count++;
                end
            end
            if (rd_valid && rd_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected sample", rd_data, -1);
                end else begin
                    exp_t it;
                    it = sb_q.pop_front();
                    check(rd_data == it.val, it.tag, "rd_data (R1 R6 order)", rd_data, it.val);
                    check(rd_last == it.last, it.tag, "rd_last R6", rd_last, it.last);
                    if (rd_last) model_count--;
                end
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic pulse_accept();
        @(posedge clk); #3; accept = 1'b1;
        @(posedge clk); #3; accept = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] held;
        cycles(3);
        @(posedge clk); #3; rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(!rd_valid && !buf_full && !busy && ovf_count == 0, "R8", "reset state",
              {rd_valid, buf_full, busy}, 0);

        // R8: window reaching words from before reset reads zeros
        rd_ready = 1'b1; cur_tag = "R8";
        cycles(4);
        pulse_accept();
        cycles(10);

        // R1: single accept after the pipeline is full of live words
        cycles(150); cur_tag = "R1";
        pulse_accept();
        cycles(10);

        // R7: valid only after capture completes, holds under stall
        rd_ready = 1'b0; cur_tag = "R7";
        @(posedge clk); #3; accept = 1'b1;
        @(posedge clk); #3; accept = 1'b0;
        @(negedge clk); check(!rd_valid, "R7", "valid after 1st sample", rd_valid, 0);
        @(negedge clk); check(!rd_valid, "R7", "valid after 2nd sample", rd_valid, 0);
        @(negedge clk); check(rd_valid, "R7", "valid after 3rd sample", rd_valid, 1);
        held = rd_data;
        cycles(3);
        @(negedge clk);
        check(rd_valid && rd_data == held, "R7", "stalled data held", rd_data, held);
        rd_ready = 1'b1;
        cycles(10);

        // R2: accepts on three consecutive clocks
        cur_tag = "R2";
        @(posedge clk); #3; accept = 1'b1;
        cycles(3);
        accept = 1'b0;
        cycles(20);
        check(model_count == 0, "R2", "events drained", model_count, 0);

        // R5 then R3: fill with readout stalled, then overflow
        rd_ready = 1'b0; cur_tag = "R5";
        for (int i = 0; i < NE; i++) begin
            pulse_accept();
        end
        cycles(4);
        @(negedge clk);
        check(buf_full && busy, "R5", "full after eight events", buf_full, 1);
        cur_tag = "R3";
        pulse_accept();
        pulse_accept();
        cycles(2);
        @(negedge clk);
        check(ovf_count == OW'(2), "R3", "dropped accepts", ovf_count, 2);

        // R9: accept held while readout retires events from a full buffer
        cur_tag = "R9";
        @(posedge clk); #3; accept = 1'b1; rd_ready = 1'b1;
        cycles(8);
        accept = 1'b0;
        for (int i = 0; i < 200 && sb_q.size() != 0; i++) cycles(1);
        cycles(4);
        @(negedge clk);
        check(sb_q.size() == 0 && !rd_valid && !buf_full, "R9", "buffer drained",
              sb_q.size(), 0);
        check(ovf_count == OW'(exp_ovf), "R9", "final overflow count", ovf_count, exp_ovf);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL R6 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule